// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the four-bit status word of a small nibble-wide processor: a carry/borrow flag, a branch flag, a spare bit that always reads zero, and the global interrupt-enable flag. Each clock it folds in the flag results reported by the ALU, according to the class of the operation just executed. It also honours a group of single-cycle strobes issued by the instruction decoder: a direct load of the whole word, set-branch, toggle-branch, disable-interrupt, enable-interrupt, return-from-interrupt and sleep.

The flags are registered and change on the rising clock edge after the inputs that cause the change. The interrupt-accept output is combinational. It gates the maskable interrupt request with the interrupt-enable flag currently held, so an interrupt controller sitting next to the block sees only requests that may be taken. Reset is not routed through this gate.

Top module: `nib_ccr`

## Requirements
- R1: An active-low reset clears the whole flag word to 4'b0000.
- R2: Flag word layout: bit 0 is carry, bit 1 is branch, bit 2 always reads 0, bit 3 is interrupt enable. A direct write loads bits 0, 1 and 3 from `wr_data_i` and discards bit 2.
- R3: A direct write takes priority over every other flag source in the same cycle, including ALU results and all strobes.
- R4: `op_class_i` = 1 (arithmetic) loads carry from `alu_carry_i` and branch from `alu_branch_i`.
- R5: `op_class_i` = 3 (shift/rotate) loads carry from `alu_carry_i`, which carries the bit shifted out, and loads branch from `alu_branch_i`.
- R6: `op_class_i` = 2 (Boolean logic) loads branch from `alu_branch_i` and leaves carry unchanged.
- R7: `op_class_i` = 0 (no ALU operation) leaves carry and branch unchanged when no branch strobe is present.
- R8: `set_br_i` forces branch to 1. `tog_br_i` inverts the held branch flag. `set_br_i` wins over `tog_br_i`, and both win over the ALU branch result.
- R9: `di_i` clears interrupt enable. `ei_i`, `rti_i` and `sleep_i` each set it. With the default `CLEAR_WINS` = 1, a clear in the same cycle as a set leaves the flag cleared.
- R10: `irq_accept_o` is high exactly when `irq_req_i` is high and the held interrupt-enable flag is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_class_i | input | 2 | ALU operation class: 0 none, 1 arithmetic, 2 logic, 3 shift/rotate |
| alu_carry_i | input | 1 | Carry, borrow or shifted-out bit from the ALU |
| alu_branch_i | input | 1 | Branch condition result from the ALU |
| wr_en_i | input | 1 | Direct write strobe |
| wr_data_i | input | 4 | Direct write data |
| set_br_i | input | 1 | Set-branch strobe |
| tog_br_i | input | 1 | Toggle-branch strobe |
| di_i | input | 1 | Disable-interrupt strobe |
| ei_i | input | 1 | Enable-interrupt strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| sleep_i | input | 1 | Sleep strobe |
| irq_req_i | input | 1 | Maskable interrupt request |
| flags_o | output | 4 | Registered flag word |
| irq_accept_o | output | 1 | Gated interrupt request |

## Verification
The bound checker watches several properties on every cycle after reset:
- the zero spare bit;
- the result of a direct write one cycle later;
- that carry holds across Boolean operations;
- that interrupt enable clears after the disable strobe and sets after any of its set sources;
- that interrupt acceptance never passes while interrupt enable is clear.

Other behaviours are shown only by the bench's directed and random scenarios, compared against its reference model:
- the three-level priority on the branch flag;
- the carry loading rules for arithmetic and shift;
- the clearing of a populated word by a mid-run reset.

// File: rtl/nib_ccr_pkg.sv
package nib_ccr_pkg;
   localparam int unsigned FLAG_W  = 4;
   localparam int unsigned OPC_W   = 2;
   localparam int unsigned C_BIT   = 0;
   localparam int unsigned B_BIT   = 1;
   localparam int unsigned RSV_BIT = 2;
   localparam int unsigned I_BIT   = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_NONE  = 2'd0,
      OPC_ARITH = 2'd1,
      OPC_LOGIC = 2'd2,
      OPC_SHIFT = 2'd3
   } opc_e;
endpackage

// File: rtl/nib_ccr_carry.sv
module nib_ccr_carry
   import nib_ccr_pkg::*;
(
   input  logic carry_q_i,
   input  opc_e opc_i,
   input  logic alu_carry_i,
   output logic carry_d_o
);
   always_comb begin
      unique case (opc_i)
         OPC_ARITH, OPC_SHIFT: carry_d_o = alu_carry_i;
         default:              carry_d_o = carry_q_i;
      endcase
   end
endmodule

// File: rtl/nib_ccr_branch.sv
module nib_ccr_branch
   import nib_ccr_pkg::*;
(
   input  logic branch_q_i,
   input  opc_e opc_i,
   input  logic alu_branch_i,
   input  logic set_i,
   input  logic tog_i,
   output logic branch_d_o
);
   always_comb begin
      if (set_i)
         branch_d_o = 1'b1;
      else if (tog_i)
         branch_d_o = ~branch_q_i;
      else if (opc_i != OPC_NONE)
         branch_d_o = alu_branch_i;
      else
         branch_d_o = branch_q_i;
   end
endmodule

// File: rtl/nib_ccr_ie.sv
module nib_ccr_ie #(
   parameter int unsigned CLEAR_WINS = 1
) (
   input  logic ie_q_i,
   input  logic clr_i,
   input  logic ei_i,
   input  logic rti_i,
   input  logic sleep_i,
   output logic ie_d_o
);
   logic any_set;
   assign any_set = ei_i | rti_i | sleep_i;

   generate
      if (CLEAR_WINS != 0) begin : g_clear_first
         always_comb begin
            if (clr_i)        ie_d_o = 1'b0;
            else if (any_set) ie_d_o = 1'b1;
            else              ie_d_o = ie_q_i;
         end
      end else begin : g_set_first
         always_comb begin
            if (any_set)      ie_d_o = 1'b1;
            else if (clr_i)   ie_d_o = 1'b0;
            else              ie_d_o = ie_q_i;
         end
      end
   endgenerate
endmodule

// File: rtl/nib_ccr.sv
module nib_ccr
   import nib_ccr_pkg::*;
#(
   parameter int unsigned CLEAR_WINS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  op_class_i,
   input  logic              alu_carry_i,
   input  logic              alu_branch_i,
   input  logic              wr_en_i,
   input  logic [FLAG_W-1:0] wr_data_i,
   input  logic              set_br_i,
   input  logic              tog_br_i,
   input  logic              di_i,
   input  logic              ei_i,
   input  logic              rti_i,
   input  logic              sleep_i,
   input  logic              irq_req_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              irq_accept_o
);
   initial begin : elab_chk
      assert (CLEAR_WINS <= 1) else $error("CLEAR_WINS must be 0 or 1");
   end

   opc_e opc;
   logic c_q, b_q, i_q;
   logic c_nx, b_nx, i_nx;
   logic unused_rsv;

   assign opc        = opc_e'(op_class_i);
   assign unused_rsv = wr_data_i[RSV_BIT];

   nib_ccr_carry u_carry (
      .carry_q_i   (c_q),
      .opc_i       (opc),
      .alu_carry_i (alu_carry_i),
      .carry_d_o   (c_nx)
   );

   nib_ccr_branch u_branch (
      .branch_q_i   (b_q),
      .opc_i        (opc),
      .alu_branch_i (alu_branch_i),
      .set_i        (set_br_i),
      .tog_i        (tog_br_i),
      .branch_d_o   (b_nx)
   );

   nib_ccr_ie #(.CLEAR_WINS(CLEAR_WINS)) u_ie (
      .ie_q_i  (i_q),
      .clr_i   (di_i),
      .ei_i    (ei_i),
      .rti_i   (rti_i),
      .sleep_i (sleep_i),
      .ie_d_o  (i_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= 1'b0;
         b_q <= 1'b0;
         i_q <= 1'b0;
      end else if (wr_en_i) begin
         c_q <= wr_data_i[C_BIT];
         b_q <= wr_data_i[B_BIT];
         i_q <= wr_data_i[I_BIT];
      end else begin
         c_q <= c_nx;
         b_q <= b_nx;
         i_q <= i_nx;
      end
   end

   always_comb begin
      flags_o          = '0;
      flags_o[C_BIT]   = c_q;
      flags_o[B_BIT]   = b_q;
      flags_o[I_BIT]   = i_q;
   end

   assign irq_accept_o = irq_req_i & i_q;
endmodule

// File: rtl/nib_ccr_chk.sv
module nib_ccr_chk
   import nib_ccr_pkg::*;
#(
   parameter int unsigned CLEAR_WINS = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OPC_W-1:0]  op_class_i,
   input logic              wr_en_i,
   input logic [FLAG_W-1:0] wr_data_i,
   input logic              di_i,
   input logic              ei_i,
   input logic              rti_i,
   input logic              sleep_i,
   input logic              irq_req_i,
   input logic [FLAG_W-1:0] flags_o,
   input logic              irq_accept_o
);
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[RSV_BIT] == 1'b0);

   p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (flags_o[C_BIT] == $past(wr_data_i[C_BIT]) &&
                   flags_o[B_BIT] == $past(wr_data_i[B_BIT]) &&
                   flags_o[I_BIT] == $past(wr_data_i[I_BIT])));

   p_logic_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && op_class_i == OPC_LOGIC) |=> $stable(flags_o[C_BIT]));

   p_none_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && op_class_i == OPC_NONE) |=> $stable(flags_o[C_BIT]));

   generate
      if (CLEAR_WINS != 0) begin : g_clr
         p_di_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i && di_i) |=> !flags_o[I_BIT]);
         p_set_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i && !di_i && (ei_i || rti_i || sleep_i)) |=> flags_o[I_BIT]);
      end else begin : g_set
         p_set_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i && (ei_i || rti_i || sleep_i)) |=> flags_o[I_BIT]);
         p_di_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en_i && di_i && !(ei_i || rti_i || sleep_i)) |=> !flags_o[I_BIT]);
      end
   endgenerate

   p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_o[I_BIT] |-> !irq_accept_o);

   p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept_o |-> irq_req_i);
endmodule

bind nib_ccr nib_ccr_chk #(.CLEAR_WINS(CLEAR_WINS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_class_i   (op_class_i),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .di_i         (di_i),
   .ei_i         (ei_i),
   .rti_i        (rti_i),
   .sleep_i      (sleep_i),
   .irq_req_i    (irq_req_i),
   .flags_o      (flags_o),
   .irq_accept_o (irq_accept_o)
);

// File: tb/nib_ccr_tb_top.sv
module nib_ccr_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_class_i = '0;
   logic       alu_carry_i = 1'b0, alu_branch_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [3:0] wr_data_i = '0;
   logic       set_br_i = 1'b0, tog_br_i = 1'b0;
   logic       di_i = 1'b0, ei_i = 1'b0, rti_i = 1'b0, sleep_i = 1'b0;
   logic       irq_req_i = 1'b0;
   logic [3:0] flags_o;
   logic       irq_accept_o;

   int total = 0;
   int bad = 0;
   bit m_c = 0, m_b = 0, m_i = 0;
   bit done = 0;

   always #5 clk = ~clk;

   nib_ccr dut_i (.*);

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_in();
      op_class_i = 0; alu_carry_i = 0; alu_branch_i = 0; wr_en_i = 0;
      wr_data_i = 0; set_br_i = 0; tog_br_i = 0; di_i = 0; ei_i = 0;
      rti_i = 0; sleep_i = 0; irq_req_i = 0;
   endtask

   // Called at a falling edge after inputs are set; runs one clock.
   task automatic cyc(string req);
      #1;
      check("R10", {3'b0, irq_accept_o}, {3'b0, irq_req_i & m_i});
      @(posedge clk);
      if (wr_en_i) begin
         m_c = wr_data_i[0]; m_b = wr_data_i[1]; m_i = wr_data_i[3];
      end else begin
         if (op_class_i == 1 || op_class_i == 3) m_c = alu_carry_i;
         if (set_br_i) m_b = 1;
         else if (tog_br_i) m_b = !m_b;
         else if (op_class_i != 0) m_b = alu_branch_i;
         if (di_i) m_i = 0;
         else if (ei_i || rti_i || sleep_i) m_i = 1;
      end
      @(negedge clk);
      check(req, flags_o, {m_i, 1'b0, m_b, m_c});
      clear_in();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1", flags_o, 4'b0000);
      rst_n = 1;
      @(negedge clk);
      // R2 layout / spare bit dropped
      wr_en_i = 1; wr_data_i = 4'b1111; cyc("R2");
      wr_en_i = 1; wr_data_i = 4'b0100; cyc("R2");
      // R3 write beats ALU and strobes
      wr_en_i = 1; wr_data_i = 4'b0001; op_class_i = 1; alu_carry_i = 0;
      alu_branch_i = 1; set_br_i = 1; ei_i = 1; cyc("R3");
      // R4 arithmetic
      op_class_i = 1; alu_carry_i = 1; alu_branch_i = 1; cyc("R4");
      op_class_i = 1; alu_carry_i = 0; alu_branch_i = 0; cyc("R4");
      // R5 shift
      op_class_i = 3; alu_carry_i = 1; alu_branch_i = 0; cyc("R5");
      // R6 logic keeps carry
      op_class_i = 2; alu_carry_i = 0; alu_branch_i = 1; cyc("R6");
      // R7 none holds
      op_class_i = 0; alu_carry_i = 0; alu_branch_i = 0; cyc("R7");
      // R8 branch strobes
      tog_br_i = 1; cyc("R8");
      set_br_i = 1; tog_br_i = 1; cyc("R8");
      tog_br_i = 1; op_class_i = 2; alu_branch_i = 1; cyc("R8");
      // R9 interrupt enable
      ei_i = 1; cyc("R9");
      irq_req_i = 1; cyc("R10");
      di_i = 1; cyc("R9");
      rti_i = 1; cyc("R9");
      di_i = 1; sleep_i = 1; cyc("R9");
      sleep_i = 1; irq_req_i = 1; cyc("R9");
      di_i = 1; irq_req_i = 1; cyc("R10");
      // random mix
      for (int k = 0; k < 3000; k++) begin
         op_class_i = 2'($urandom); alu_carry_i = 1'($urandom);
         alu_branch_i = 1'($urandom); wr_en_i = ($urandom % 8) == 0;
         wr_data_i = 4'($urandom); set_br_i = ($urandom % 4) == 0;
         tog_br_i = ($urandom % 3) == 0; di_i = ($urandom % 4) == 0;
         ei_i = ($urandom % 5) == 0; rti_i = ($urandom % 6) == 0;
         sleep_i = ($urandom % 7) == 0; irq_req_i = 1'($urandom);
         cyc(wr_en_i ? "R3" : "R4");
      end
      // R1 mid-run reset
      wr_en_i = 1; wr_data_i = 4'b1011; cyc("R2");
      rst_n = 0; m_c = 0; m_b = 0; m_i = 0;
      #2;
      check("R1", flags_o, 4'b0000);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule